// File: doc/BRIEF.md
# Prioritised Vectoring Interrupt Controller

This block gathers thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents one interrupt request to a processor. The request is a 3-bit level and an 8-bit vector number. Each source has its own 8-bit control register. That register holds an autovector enable, a 3-bit level and a 2-bit sub-priority. The five low bits of the register form a ranking key.

A global mask register removes sources from contention. A read-only pending register shows the sampled input lines. Arbitration picks the unmasked pending source with the largest key. The vector then comes from one of two places. With autovectoring on, it is derived from the level. Otherwise it comes from one of three software-programmed vector registers, or from a fixed default code.

Software reaches the registers through a simple single-cycle write port and a combinational read port. The processor acknowledge cycle and nesting are handled outside the block.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset these values hold:
  - Control registers of sources 1..7 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. Source 8 reads 0x1C, sources 9..11 read 0x80, and sources 12..13 read 0x00.
  - The mask reads 0x3FFE. The three vector registers read 0x0F.
  - The level and vector outputs are 0.
- R2: The control register of source n sits at byte offset 0x13+n (0x14..0x20). Writes take data bits 7:0, and all 8 bits read back. Bit 7 enables the autovector, bits 4:2 give the level and bits 1:0 the sub-priority. The ranking key is bits 4:0.
- R3: Pending bit n at offset 0x3A is the input line of source n, registered once. Bit 0 and bits above 13 read 0. Writes to 0x3A have no effect.
- R4: The 16-bit mask sits at offset 0x36. A source whose mask bit n is 1 never wins arbitration.
- R5: Among pending, unmasked sources, the one with the strictly greatest key wins. On equal keys, the lower-numbered source wins.
- R6: When no source is eligible, or the winning key is below 4, the level output and the vector output are both 0. A winning key of 4 or more is presented.
- R7: When the winner has its autovector enabled, the vector is 24 plus its level.
- R8: When the winner has its autovector disabled, the vector comes from a register or a fixed code:
  - Source 8 uses the register at 0x48.
  - Source 12 uses the register at 0x49.
  - Source 13 uses the register at 0x4A.
  - Any other source gives 0x0F.
- R9: The level and vector outputs are registered. They reflect the pending, mask, control and vector register values one clock edge after those change. A change on a source line therefore shows two edges later.
- R10: Reads of offsets that are not mapped return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 (bits 13:1) | Level-sensitive source lines; bit n is source n |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Byte offset for reads and writes |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, combinational |
| irq_level_o | output | 3 | Presented interrupt level, 0 when idle |
| irq_vector_o | output | 8 | Presented vector number, 0 when idle |

## Verification
Two things can fall in the same cycle: a register write that changes arbitration, and a source edge entering the pending stage. The bench provokes this by switching source lines in the very cycles where it rewrites the mask, the control registers and the vector registers. It judges the result with a clock-accurate behavioural model that applies the one-edge pending delay and the one-edge output delay independently. Directed checks cover the following corner cases:
- ties between sources,
- a key just below and just at the suppression threshold,
- masked winners,
- writes to read-only and unmapped offsets.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int KEY_W = 5;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam int CTRL_W = 8;
  localparam int AUTO_BIT = 7;
  localparam logic [VEC_W-1:0] AUTO_BASE = 8'd24;
  localparam logic [VEC_W-1:0] DFLT_VEC = 8'h0F;

  // reset control value per source index
  function automatic logic [CTRL_W-1:0] ctrl_rst(int unsigned idx);
    if (idx >= 1 && idx <= 7) return CTRL_W'(idx * 4);
    else if (idx == 8)        return 8'h1C;
    else if (idx <= 11)       return 8'h80;
    else                      return 8'h00;
  endfunction
endpackage

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int CTRL_BASE = 'h14,
  parameter int MASK_ADDR = 'h36,
  parameter int PEND_ADDR = 'h3A,
  parameter int SWV_ADDR  = 'h48,
  parameter int PV0_ADDR  = 'h49,
  parameter int PV1_ADDR  = 'h4A,
  parameter int MASK_RST  = 'h3FFE
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NSRC:1]                src_i,
  input  logic                         we_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                rdata_o,
  output logic [NSRC:1][KEY_W-1:0]     key_o,
  output logic [NSRC:1]                auto_o,
  output logic [NSRC:1]                mask_o,
  output logic [NSRC:1]                pend_o,
  output logic [VEC_W-1:0]             swv_o,
  output logic [VEC_W-1:0]             pv0_o,
  output logic [VEC_W-1:0]             pv1_o
);
  logic [CTRL_W-1:0] ctrl_q [NSRC:1];
  logic [DW-1:0]     mask_q;
  logic [NSRC:1]     pend_q;
  logic [VEC_W-1:0]  swv_q, pv0_q, pv1_q;

  function automatic logic hit(int a);
    return we_i && (addr_i == AW'(a));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i <= NSRC; i++) ctrl_q[i] <= ctrl_rst(i);
    end else begin
      for (int i = 1; i <= NSRC; i++)
        if (hit(CTRL_BASE + i - 1)) ctrl_q[i] <= wdata_i[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= DW'(MASK_RST);
      swv_q  <= DFLT_VEC;
      pv0_q  <= DFLT_VEC;
      pv1_q  <= DFLT_VEC;
    end else begin
      if (hit(MASK_ADDR)) mask_q <= wdata_i;
      if (hit(SWV_ADDR))  swv_q  <= wdata_i[VEC_W-1:0];
      if (hit(PV0_ADDR))  pv0_q  <= wdata_i[VEC_W-1:0];
      if (hit(PV1_ADDR))  pv1_q  <= wdata_i[VEC_W-1:0];
    end
  end

  // pending stage: plain sample of the level inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= src_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 1; i <= NSRC; i++)
      if (addr_i == AW'(CTRL_BASE + i - 1)) rdata_o = DW'(ctrl_q[i]);
    if (addr_i == AW'(MASK_ADDR)) rdata_o = mask_q;
    if (addr_i == AW'(PEND_ADDR)) rdata_o = DW'({pend_q, 1'b0});
    if (addr_i == AW'(SWV_ADDR))  rdata_o = DW'(swv_q);
    if (addr_i == AW'(PV0_ADDR))  rdata_o = DW'(pv0_q);
    if (addr_i == AW'(PV1_ADDR))  rdata_o = DW'(pv1_q);
  end

  always_comb begin
    for (int i = 1; i <= NSRC; i++) begin
      key_o[i]  = ctrl_q[i][KEY_W-1:0];
      auto_o[i] = ctrl_q[i][AUTO_BIT];
    end
  end

  assign mask_o = mask_q[NSRC:1];
  assign pend_o = pend_q;
  assign swv_o  = swv_q;
  assign pv0_o  = pv0_q;
  assign pv1_o  = pv1_q;

  p_pend_tracks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_o == $past(src_i));
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC = 13,
  localparam int IW  = $clog2(NSRC + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSRC:1][KEY_W-1:0] key_i,
  input  logic [NSRC:1]            mask_i,
  input  logic [NSRC:1]            pend_i,
  output logic                     valid_o,
  output logic [IW-1:0]            idx_o,
  output logic [LVL_W-1:0]         lvl_o
);
  logic [KEY_W-1:0] best_key;
  logic [IW-1:0]    best_idx;

  // ascending scan, strict compare keeps the lowest index on ties
  always_comb begin
    best_key = '0;
    best_idx = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (pend_i[i] && !mask_i[i] && (key_i[i] > best_key)) begin
        best_key = key_i[i];
        best_idx = IW'(i);
      end
    end
  end

  // keys below 4 carry level 0 and are never presented
  assign valid_o = best_key[KEY_W-1:KEY_W-LVL_W] != '0;
  assign idx_o   = best_idx;
  assign lvl_o   = best_key[KEY_W-1:KEY_W-LVL_W];

  p_winner_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && !mask_i[idx_o]));
  p_winner_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> key_i[idx_o][KEY_W-1:KEY_W-LVL_W] == lvl_o);
endmodule

// File: rtl/intc_vector.sv
`timescale 1ns/1ps
module intc_vector
  import intc_pkg::*;
#(
  parameter int NSRC    = 13,
  parameter int SWV_SRC = 8,
  parameter int PV0_SRC = 12,
  parameter int PV1_SRC = 13,
  localparam int IW     = $clog2(NSRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [NSRC:1]     auto_i,
  input  logic [VEC_W-1:0]  swv_i,
  input  logic [VEC_W-1:0]  pv0_i,
  input  logic [VEC_W-1:0]  pv1_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [VEC_W-1:0] user_vec;
  logic [VEC_W-1:0] vec_d;
  logic [LVL_W-1:0] lvl_d;

  always_comb begin
    if (idx_i == IW'(SWV_SRC))      user_vec = swv_i;
    else if (idx_i == IW'(PV0_SRC)) user_vec = pv0_i;
    else if (idx_i == IW'(PV1_SRC)) user_vec = pv1_i;
    else                            user_vec = DFLT_VEC;
  end

  always_comb begin
    lvl_d = '0;
    vec_d = '0;
    if (valid_i) begin
      lvl_d = lvl_i;
      vec_d = auto_i[idx_i] ? AUTO_BASE + VEC_W'(lvl_i) : user_vec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= '0;
      vec_o <= '0;
    end else begin
      lvl_o <= lvl_d;
      vec_o <= vec_d;
    end
  end

  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (lvl_o == '0 && vec_o == '0));
  p_autovec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && auto_i[idx_i]) |=> vec_o == AUTO_BASE + VEC_W'(lvl_o));
  p_one_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (lvl_o == $past(lvl_i) && lvl_o != '0));
endmodule

// File: rtl/prio_vec_intc.sv
`timescale 1ns/1ps
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int CTRL_BASE = 'h14,
  parameter int MASK_ADDR = 'h36,
  parameter int PEND_ADDR = 'h3A,
  parameter int SWV_ADDR  = 'h48,
  parameter int PV0_ADDR  = 'h49,
  parameter int PV1_ADDR  = 'h4A,
  parameter int MASK_RST  = 'h3FFE,
  parameter int SWV_SRC   = 8,
  parameter int PV0_SRC   = 12,
  parameter int PV1_SRC   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC:1]     src_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [2:0]        irq_level_o,
  output logic [7:0]        irq_vector_o
);
  localparam int IW = $clog2(NSRC + 1);

  logic [NSRC:1][KEY_W-1:0] key;
  logic [NSRC:1]            auto_en, mask, pend;
  logic [VEC_W-1:0]         swv, pv0, pv1;
  logic                     win_valid;
  logic [IW-1:0]            win_idx;
  logic [LVL_W-1:0]         win_lvl;

  intc_regs #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .CTRL_BASE(CTRL_BASE), .MASK_ADDR(MASK_ADDR),
    .PEND_ADDR(PEND_ADDR), .SWV_ADDR(SWV_ADDR), .PV0_ADDR(PV0_ADDR),
    .PV1_ADDR(PV1_ADDR), .MASK_RST(MASK_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .key_o(key), .auto_o(auto_en), .mask_o(mask), .pend_o(pend),
    .swv_o(swv), .pv0_o(pv0), .pv1_o(pv1)
  );

  intc_arbiter #(.NSRC(NSRC)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_i(key), .mask_i(mask), .pend_i(pend),
    .valid_o(win_valid), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  intc_vector #(
    .NSRC(NSRC), .SWV_SRC(SWV_SRC), .PV0_SRC(PV0_SRC), .PV1_SRC(PV1_SRC)
  ) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(win_valid), .idx_i(win_idx),
    .lvl_i(win_lvl), .auto_i(auto_en), .swv_i(swv), .pv0_i(pv0), .pv1_i(pv1),
    .lvl_o(irq_level_o), .vec_o(irq_vector_o)
  );
endmodule

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_vec_intc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_level_o(lvl), .irq_vector_o(vec)
  );

  // behavioural reference state
  logic [7:0]  m_ctrl [1:13];
  logic [15:0] m_mask;
  logic [13:1] m_pend;
  logic [7:0]  m_sw, m_p0, m_p1;
  logic [2:0]  m_lvl;
  logic [7:0]  m_vec;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void resolve(output logic [2:0] l, output logic [7:0] v);
    int best = -1;
    int bk = -1;
    for (int i = 13; i >= 1; i--) begin
      if (m_pend[i] && !m_mask[i]) begin
        int k = int'(m_ctrl[i] & 8'h1F);
        if (k >= bk) begin bk = k; best = i; end
      end
    end
    if (best < 0 || bk < 4) begin
      l = 0; v = 0;
    end else begin
      l = 3'(bk / 4);
      if (m_ctrl[best][7])  v = 8'(24 + bk / 4);
      else if (best == 8)   v = m_sw;
      else if (best == 12)  v = m_p0;
      else if (best == 13)  v = m_p1;
      else                  v = 8'h0F;
    end
  endfunction

  function automatic logic [15:0] mread(input logic [7:0] a);
    if (a >= 8'h14 && a <= 8'h20) return {8'h00, m_ctrl[a - 8'h13]};
    case (a)
      8'h36: return m_mask;
      8'h3A: return {2'b00, m_pend, 1'b0};
      8'h48: return {8'h00, m_sw};
      8'h49: return {8'h00, m_p0};
      8'h4A: return {8'h00, m_p1};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 13; i++)
        m_ctrl[i] = (i <= 7) ? 8'(i * 4) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
      m_mask = 16'h3FFE; m_sw = 8'h0F; m_p0 = 8'h0F; m_p1 = 8'h0F;
      m_pend = '0; m_lvl = 0; m_vec = 0;
    end else begin
      logic [2:0] nl;
      logic [7:0] nv;
      resolve(nl, nv);
      m_pend = src;
      if (we) begin
        if (addr >= 8'h14 && addr <= 8'h20) m_ctrl[addr - 8'h13] = wd[7:0];
        else if (addr == 8'h36) m_mask = wd;
        else if (addr == 8'h48) m_sw = wd[7:0];
        else if (addr == 8'h49) m_p0 = wd[7:0];
        else if (addr == 8'h4A) m_p1 = wd[7:0];
      end
      m_lvl = nl; m_vec = nv;
    end
  end

  // every-cycle comparison, sampled between edges
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R9 level vs model", 32'(lvl), 32'(m_lvl));
      chk("R9 vector vs model", 32'(vec), 32'(m_vec));
      chk("R2/R3/R4 readback vs model", 32'(rdata), 32'(mread(addr)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic out(input string tag, input logic [2:0] l, input logic [7:0] v);
    #1;
    chk({tag, " level"}, 32'(lvl), 32'(l));
    chk({tag, " vector"}, 32'(vec), 32'(v));
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    out("R1 reset outputs", 3'd0, 8'h00);
    rd("R1 ctrl1 reset", 8'h14, 16'h0004);
    rd("R1 ctrl7 reset", 8'h1A, 16'h001C);
    rd("R1 ctrl8 reset", 8'h1B, 16'h001C);
    rd("R1 ctrl9 reset", 8'h1C, 16'h0080);
    rd("R1 ctrl12 reset", 8'h1F, 16'h0000);
    rd("R1 mask reset", 8'h36, 16'h3FFE);
    rd("R1 sw vector reset", 8'h48, 16'h000F);

    // masked pending source
    src[3] = 1'b1;
    settle(3);
    rd("R3 pending bit3", 8'h3A, 16'h0008);
    out("R4 masked source idle", 3'd0, 8'h00);
    wr(8'h3A, 16'hFFFF);
    settle(2);
    rd("R3 pending read-only", 8'h3A, 16'h0008);

    wr(8'h36, 16'h3FF6);
    settle(3);
    out("R8 default vector src3", 3'd3, 8'h0F);
    wr(8'h16, 16'h008E);
    settle(3);
    out("R7 autovector src3", 3'd3, 8'd27);

    // tie between 8 and 12, written while sources change
    @(negedge clk); src[8] = 1'b1; src[12] = 1'b1;
    wr(8'h36, 16'h2EF6);
    wr(8'h1F, 16'h001C);
    wr(8'h48, 16'h0033);
    wr(8'h49, 16'h0051);
    wr(8'h4A, 16'h0061);
    settle(3);
    out("R5 tie lower index", 3'd7, 8'h33);
    wr(8'h1F, 16'h001D);
    settle(3);
    out("R5 greater key wins R8 reg 0x49", 3'd7, 8'h51);
    wr(8'h36, 16'h3EF6);
    settle(3);
    out("R4 mask removes winner", 3'd7, 8'h33);
    @(negedge clk); src[13] = 1'b1;
    wr(8'h36, 16'h1EF6);
    wr(8'h20, 16'h001F);
    settle(3);
    out("R8 reg 0x4A for src13", 3'd7, 8'h61);

    // suppression threshold
    @(negedge clk); src = '0; src[1] = 1'b1;
    wr(8'h36, 16'h3FFC);
    wr(8'h14, 16'h0003);
    settle(3);
    out("R6 key 3 suppressed", 3'd0, 8'h00);
    wr(8'h14, 16'h0004);
    settle(3);
    out("R6 key 4 presented", 3'd1, 8'h0F);

    // two-edge latency from source line
    @(negedge clk); src[1] = 1'b0;
    @(negedge clk);
    out("R9 after one edge", 3'd1, 8'h0F);
    @(negedge clk);
    out("R9 after two edges", 3'd0, 8'h00);

    // unmapped offsets
    rd("R10 unmapped read", 8'h00, 16'h0000);
    wr(8'h21, 16'h00FF);
    wr(8'h13, 16'h00FF);
    rd("R10 unmapped 0x21", 8'h21, 16'h0000);
    rd("R10 ctrl1 untouched", 8'h14, 16'h0004);
    rd("R10 ctrl13 untouched", 8'h20, 16'h001F);

    // field layout with spare bits
    @(negedge clk); src[2] = 1'b1;
    wr(8'h15, 16'h00E9);
    wr(8'h36, 16'h3FFA);
    settle(3);
    rd("R2 ctrl2 readback", 8'h15, 16'h00E9);
    out("R2 level field R7", 3'd2, 8'd26);

    settle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule